// File: doc/BRIEF.md
# Fractional Accumulator Result Rounder and Saturator

This unit turns a wide signed fractional multiply-accumulate value into a register-sized result. The accumulator arrives as a 64-bit two's-complement word. Three mode bits go with it. The narrow-mode bit selects a 16-bit result instead of a 32-bit one. The round-enable bit turns on round-half-to-even for 32-bit results. The saturate bit clamps out-of-range results instead of wrapping them.

The datapath has two registered stages. The first stage drops the fractional bits and rounds. The second stage checks the range and clamps or truncates. A result appears on `out_data` with `out_valid` two clock edges after the input is accepted. There is no back-pressure, so a new input can be accepted on every cycle. Narrow results sit in the low 16 bits of `out_data`, and the upper half is zero.

Top module: `macr_result_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `out_valid` is 0.
- R2: An input taken with `in_valid` high on edge k is presented with `out_valid` high after edge k+2. Back-to-back inputs produce back-to-back outputs in the same order. `out_valid` is high for no other cycle.
- R3: In narrow mode (`in_m16`=1) the result is accumulator bits [39:24] after rounding, interpreted as signed. `out_data[31:16]` is always zero. Rounding is always applied in this mode, and `in_rnd` has no effect on the result.
- R4: Rounding is round-half-to-even on the dropped remainder. A remainder above half adds one. A remainder equal to half adds one only when the kept value is odd. A remainder below half adds nothing. In narrow mode the remainder is 24 bits wide and half is 0x800000. Negative values round the same way on their two's-complement bits.
- R5: In wide mode (`in_m16`=0) with `in_rnd`=1, the result is accumulator bits [39:8] after rounding. The remainder is the low 8 bits, and half is 0x80.
- R6: In wide mode with `in_rnd`=0, the low 8 bits are discarded. This is an arithmetic floor, so -255 gives 0xFFFFFFFF.
- R7: With `in_sat`=1 in narrow mode, a rounded value outside [-32768, 32767] gives 0x00007FFF if it is positive and 0x00008000 if it is negative.
- R8: With `in_sat`=1 in wide mode, a rounded value outside the signed 32-bit range gives 0x7FFFFFFF if it is positive and 0x80000000 if it is negative. A value exactly at a limit passes unchanged.
- R9: With `in_sat`=0, the rounded value is truncated to its low 16 bits (narrow mode) or its low 32 bits (wide mode), with no clamping.
- R10: The range check uses the value after rounding, so a rounding carry past the limit is clamped when saturation is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_acc | input | 64 | Sign-extended fractional accumulator value |
| in_m16 | input | 1 | 1 selects a 16-bit result, 0 a 32-bit result |
| in_rnd | input | 1 | Round enable for 32-bit results |
| in_sat | input | 1 | Clamp on overflow instead of truncating |
| out_valid | output | 1 | Result is valid |
| out_data | output | 32 | Result; a 16-bit result sits in bits [15:0] |

## Verification
Some behaviours are checked by the in-RTL assertions on every cycle:
- the valid pipeline, which has no drops or spurious outputs;
- the rounded value, which always lies at the floor or one above it, and at the floor exactly when rounding is off in wide mode;
- the zero upper half for narrow results;
- the clamp codes on overflow;
- the pass-through of in-range wide values.

The bench scenarios alone can show the values that depend on the exact remainder:
- the exact half-to-even choice at each tie;
- that the round-enable bit has no effect in narrow mode;
- the negative floor;
- a rounding carry that crosses a limit and is then clamped.

// File: rtl/macr_pkg.sv
package macr_pkg;
  localparam int ACC_W      = 64;
  localparam int OUT_W      = 32;
  localparam int NARROW_W   = 16;
  localparam int NARROW_DROP = 24;
  localparam int WIDE_DROP  = 8;
  localparam int Q_W        = ACC_W - WIDE_DROP + 1;

  typedef struct packed {
    logic narrow;
    logic sat;
  } macr_mode_t;
endpackage

// File: rtl/macr_rne.sv
module macr_rne #(
  parameter int IN_W = 64,
  parameter int DROP = 8,
  parameter int Q_W  = 57
) (
  input  logic [IN_W-1:0]       acc,
  input  logic                  rnd_en,
  output logic signed [Q_W-1:0] q
);
  localparam int EXT = Q_W - (IN_W - DROP);
  localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

  logic [DROP-1:0]       rem;
  logic signed [Q_W-1:0] base;
  logic                  bump;

  always_comb begin
    rem  = acc[DROP-1:0];
    base = {{EXT{acc[IN_W-1]}}, acc[IN_W-1:DROP]};
    bump = rnd_en && ((rem > HALF) || ((rem == HALF) && base[0]));
    q    = base + Q_W'(bump);
  end
endmodule

// File: rtl/macr_round_stage.sv
module macr_round_stage
  import macr_pkg::*;
#(
  parameter int IN_W  = ACC_W,
  parameter int DROP_N = NARROW_DROP,
  parameter int DROP_W = WIDE_DROP,
  parameter int QW    = IN_W - DROP_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [IN_W-1:0]      in_acc,
  input  logic                 in_m16,
  input  logic                 in_rnd,
  input  logic                 in_sat,
  output logic                 v1,
  output logic signed [QW-1:0] q1,
  output macr_mode_t           mode1
);
  logic signed [QW-1:0] q_cand [2];

  for (genvar i = 0; i < 2; i++) begin : g_path
    localparam int DROP_I = (i == 0) ? DROP_N : DROP_W;
    logic en_i;
    assign en_i = (i == 0) ? 1'b1 : in_rnd;
    macr_rne #(.IN_W(IN_W), .DROP(DROP_I), .Q_W(QW)) u_rne (
      .acc(in_acc), .rnd_en(en_i), .q(q_cand[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      q1          <= in_m16 ? q_cand[0] : q_cand[1];
      mode1.narrow <= in_m16;
      mode1.sat    <= in_sat;
    end
  end

  // Floor of the input, derived straight from the accumulator bits.
  logic signed [QW-1:0] floor_now;
  assign floor_now = in_m16 ? QW'($signed(in_acc) >>> DROP_N)
                            : QW'($signed(in_acc) >>> DROP_W);

  // R4: a rounded value is the floor or one above it
  a_r4_round_step: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (q1 == $past(floor_now)) || (q1 == $past(floor_now) + QW'(1)));

  // R6: wide mode without rounding is an exact floor
  a_r6_floor: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_m16 && !in_rnd) |=> (q1 == $past(floor_now)));
endmodule

// File: rtl/macr_sat_stage.sv
module macr_sat_stage
  import macr_pkg::*;
#(
  parameter int QW = Q_W,
  parameter int OW = OUT_W,
  parameter int NW = NARROW_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v1,
  input  logic signed [QW-1:0] q1,
  input  macr_mode_t           mode1,
  output logic                 out_valid,
  output logic [OW-1:0]        out_data
);
  localparam logic [NW-1:0] N_MAX = {1'b0, {(NW-1){1'b1}}};
  localparam logic [NW-1:0] N_MIN = {1'b1, {(NW-1){1'b0}}};
  localparam logic [OW-1:0] W_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] W_MIN = {1'b1, {(OW-1){1'b0}}};

  logic [QW-NW:0] hi_n;
  logic [QW-OW:0] hi_w;
  logic           fits_n, fits_w, neg;
  logic [OW-1:0]  res;

  always_comb begin
    hi_n   = q1[QW-1:NW-1];
    hi_w   = q1[QW-1:OW-1];
    fits_n = (&hi_n) || (~|hi_n);
    fits_w = (&hi_w) || (~|hi_w);
    neg    = q1[QW-1];
    if (mode1.narrow) begin
      if (mode1.sat && !fits_n) res = {{(OW-NW){1'b0}}, neg ? N_MIN : N_MAX};
      else                      res = {{(OW-NW){1'b0}}, q1[NW-1:0]};
    end else begin
      if (mode1.sat && !fits_w) res = neg ? W_MIN : W_MAX;
      else                      res = q1[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
  end

  always_ff @(posedge clk) begin
    if (v1) out_data <= res;
  end

  // R2: each stage-one token yields exactly one output
  a_r2_follow: assert property (@(posedge clk) disable iff (rst)
    v1 |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> !out_valid);

  // R3: narrow results leave the upper half clear
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (v1 && mode1.narrow) |=> (out_data[OW-1:NW] == '0));

  // R7: narrow overflow gives one of the two clamp codes
  a_r7_clamp16: assert property (@(posedge clk) disable iff (rst)
    (v1 && mode1.narrow && mode1.sat && !fits_n) |=>
      (out_data[NW-1:0] == N_MAX) || (out_data[NW-1:0] == N_MIN));

  // R8: wide overflow clamps toward the sign of the value
  a_r8_clamp32: assert property (@(posedge clk) disable iff (rst)
    (v1 && !mode1.narrow && mode1.sat && !fits_w) |=>
      (out_data == ($past(neg) ? W_MIN : W_MAX)));

  // R9: wide values in range, or unsaturated, pass their low bits
  a_r9_pass32: assert property (@(posedge clk) disable iff (rst)
    (v1 && !mode1.narrow && (!mode1.sat || fits_w)) |=>
      (out_data == $past(q1[OW-1:0])));
endmodule

// File: rtl/macr_result_unit.sv
module macr_result_unit
  import macr_pkg::*;
#(
  parameter int IN_W   = ACC_W,
  parameter int OW     = OUT_W,
  parameter int NW     = NARROW_W,
  parameter int DROP_N = NARROW_DROP,
  parameter int DROP_W = WIDE_DROP
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_acc,
  input  logic            in_m16,
  input  logic            in_rnd,
  input  logic            in_sat,
  output logic            out_valid,
  output logic [OW-1:0]   out_data
);
  localparam int QW = IN_W - DROP_W + 1;

  logic                 v1;
  logic signed [QW-1:0] q1;
  macr_mode_t           mode1;

  macr_round_stage #(.IN_W(IN_W), .DROP_N(DROP_N), .DROP_W(DROP_W), .QW(QW)) u_round (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .in_m16(in_m16), .in_rnd(in_rnd), .in_sat(in_sat),
    .v1(v1), .q1(q1), .mode1(mode1)
  );

  macr_sat_stage #(.QW(QW), .OW(OW), .NW(NW)) u_sat (
    .clk(clk), .rst(rst), .v1(v1), .q1(q1), .mode1(mode1),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R1: reset empties the pipeline
  a_r1_reset: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: tb/macr_result_unit_tb.sv
`timescale 1ns/1ps
module macr_result_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_acc = '0;
  logic        in_m16 = 1'b0, in_rnd = 1'b0, in_sat = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  macr_result_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_acc(in_acc),
    .in_m16(in_m16), .in_rnd(in_rnd), .in_sat(in_sat),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] a, logic m, logic r, logic s);
    in_valid = 1'b1; in_acc = a; in_m16 = m; in_rnd = r; in_sat = s;
  endtask

  // One transaction: drive at a falling edge, sample two rising edges later.
  task automatic run_one(string req, logic [63:0] a, logic m, logic r, logic s,
                         logic [31:0] exp);
    @(negedge clk); drive(a, m, r, s);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_narrow_basic;
    run_one("R3 below half", 64'h0000_0012_3440_0000, 1, 1, 0, 32'h0000_1234);
    run_one("R3 rnd ignored 0", 64'h0000_0012_34C0_0000, 1, 0, 0, 32'h0000_1235);
    run_one("R3 rnd ignored 1", 64'h0000_0012_34C0_0000, 1, 1, 0, 32'h0000_1235);
    run_one("R3 negative", 64'hFFFF_FFFF_FE80_0000, 1, 0, 0, 32'h0000_FFFE);
  endtask

  task automatic t_narrow_ties;
    run_one("R4 tie even", 64'h0000_0012_3480_0000, 1, 1, 0, 32'h0000_1234);
    run_one("R4 tie odd", 64'h0000_0012_3580_0000, 1, 1, 0, 32'h0000_1236);
    run_one("R4 above half", 64'h0000_0012_3480_0001, 1, 1, 0, 32'h0000_1235);
    run_one("R4 neg tie odd", 64'hFFFF_FFFF_FF80_0000, 1, 1, 0, 32'h0000_0000);
  endtask

  task automatic t_narrow_sat;
    run_one("R7 pos clamp", 64'h0000_0080_0000_0000, 1, 0, 1, 32'h0000_7FFF);
    run_one("R7 neg clamp", 64'hFFFF_FF00_0000_0000, 1, 0, 1, 32'h0000_8000);
    run_one("R9 narrow wrap pos", 64'h0000_0080_0000_0000, 1, 0, 0, 32'h0000_8000);
    run_one("R9 narrow wrap neg", 64'hFFFF_FF00_0000_0000, 1, 0, 0, 32'h0000_0000);
  endtask

  task automatic t_wide_round;
    run_one("R5 tie even", 64'h0000_0000_1234_5680, 0, 1, 0, 32'h0012_3456);
    run_one("R5 tie odd", 64'h0000_0000_1234_5780, 0, 1, 0, 32'h0012_3458);
    run_one("R5 above half", 64'h0000_0000_1234_5681, 0, 1, 0, 32'h0012_3457);
  endtask

  task automatic t_wide_trunc;
    run_one("R6 drop", 64'h0000_0000_1234_56FF, 0, 0, 0, 32'h0012_3456);
    run_one("R6 neg floor", 64'hFFFF_FFFF_FFFF_FF01, 0, 0, 0, 32'hFFFF_FFFF);
  endtask

  task automatic t_wide_sat;
    run_one("R8 pos clamp", 64'h0000_0080_0000_0000, 0, 0, 1, 32'h7FFF_FFFF);
    run_one("R8 neg clamp", 64'hFFFF_FF00_0000_0000, 0, 0, 1, 32'h8000_0000);
    run_one("R8 at min", 64'hFFFF_FF80_0000_0000, 0, 0, 1, 32'h8000_0000);
    run_one("R9 wide wrap pos", 64'h0000_0080_0000_0000, 0, 0, 0, 32'h8000_0000);
    run_one("R9 wide wrap neg", 64'hFFFF_FF00_0000_0000, 0, 0, 0, 32'h0000_0000);
  endtask

  task automatic t_carry;
    run_one("R10 narrow carry sat", 64'h0000_007F_FFFF_0000, 1, 1, 1, 32'h0000_7FFF);
    run_one("R10 narrow carry wrap", 64'h0000_007F_FFFF_0000, 1, 1, 0, 32'h0000_8000);
    run_one("R10 wide carry sat", 64'h0000_007F_FFFF_FFC0, 0, 1, 1, 32'h7FFF_FFFF);
  endtask

  task automatic t_back_to_back;
    @(negedge clk); drive(64'h0000_0000_0000_0100, 0, 0, 0);
    @(negedge clk); drive(64'h0000_0000_0000_0200, 0, 0, 0);
    @(negedge clk);
    check("R2 first", out_data, 32'h0000_0001);
    check("R2 first valid", {31'd0, out_valid}, 32'd1);
    drive(64'h0000_0000_0300_0000, 1, 0, 0);
    @(negedge clk); in_valid = 1'b0;
    check("R2 second", out_data, 32'h0000_0002);
    check("R2 second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R2 third", out_data, 32'h0000_0003);
    check("R2 third valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R2 idle", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_narrow_basic();
    t_narrow_ties();
    t_narrow_sat();
    t_wide_round();
    t_wide_trunc();
    t_wide_sat();
    t_carry();
    t_back_to_back();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule